// File: doc/BRIEF.md
# Memory protection region bounds decoder

This block turns the protection settings of a set of memory protection entries into inclusive byte-address bounds. Each entry has a two-bit matching-mode field and an address register that holds a word address (byte address bits XLEN+1 down to 2). For every entry the block keeps a registered lower bound, upper bound and active flag. An access checker elsewhere can then decide whether an entry matches with two plain compares, without decoding anything on its own critical path.

The configuration and address registers themselves live outside the block and are presented as flat input vectors. Alongside them come two strobe vectors that mark which entry's mode or address was accepted in the current cycle. A strobed entry's bounds are rebuilt from the inputs present in that cycle and appear one clock later. An address strobe also rebuilds the next entry, because a top-of-range entry takes its lower bound from its predecessor. Entries that are not strobed keep their bounds.

Top module: `pmp_region_bounds`

## Requirements
- R1: Mode encoding per entry is 0 = off, 1 = top-of-range, 2 = naturally aligned four bytes, 3 = naturally aligned power of two. An entry rebuilt in mode 0 shows lower and upper bound zero and active low; the other modes set active high.
- R2: In mode 1, the lower bound is the previous entry's address register times four, and the upper bound is the entry's own address register times four minus one, both XLEN+2 bits wide.
- R3: Entry 0 in mode 1 takes zero as its lower bound, whatever the other address registers hold.
- R4: In mode 2, the lower bound is the address register times four, and the upper bound is the lower bound plus three.
- R5: In mode 3, with t the count of consecutive one bits from bit 0 of the address register, the lower bound is the register with its low t bits cleared, times four. The upper bound is the lower bound plus 2^(t+3)-1. A low zero bit gives 8 bytes, a low pattern 01 gives 16 bytes, and 011 gives 32 bytes.
- R6: A mode-3 register of all ones, or of all ones below a single zero top bit, yields lower bound 0 and an upper bound of all ones over XLEN+2 bits, with no wrap.
- R7: Bounds change only on the clock edge after a strobe for that entry (or an address strobe for the entry below it). Without such a strobe they hold, even when the mode or address inputs change.
- R8: An address strobe for entry i rebuilds entries i and i+1. A mode strobe for entry i rebuilds only entry i.
- R9: During and right after reset, every bound is zero and every active flag is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | N | Per-entry strobe: mode field accepted this cycle |
| addr_wr | input | N | Per-entry strobe: address register accepted this cycle |
| mode_flat | input | 2*N | Mode field of each entry, entry i at bits 2i+1:2i |
| addr_flat | input | N*XLEN | Address register of each entry, entry i at bits i*XLEN +: XLEN |
| lo_flat | output | N*(XLEN+2) | Registered inclusive lower byte bound of each entry |
| hi_flat | output | N*(XLEN+2) | Registered inclusive upper byte bound of each entry |
| active | output | N | Entry is in a mode other than off |

## Verification
The mode-3 decoder is driven with registers ending in 0, 01 and 011. These show that the run of low ones sets the size and that the bits above the terminating zero set the base. It is also driven with the all-ones register and with the register that is all ones below a zero top bit, which show that the full-space case does not wrap. Mode 1 is tried on entry 0 and on a higher entry, which separates the forced-zero lower bound from a lower bound taken from the neighbour. The strobe tests first pulse an address strobe and then only a mode strobe on the same entry. The next entry moves only in the first case, and an entry with no strobe keeps its bounds while its inputs change.

// File: rtl/pmp_bounds_pkg.sv
package pmp_bounds_pkg;

    typedef enum logic [1:0] {
        MATCH_OFF   = 2'd0,
        MATCH_TOR   = 2'd1,
        MATCH_NA4   = 2'd2,
        MATCH_NAPOT = 2'd3
    } match_mode_e;

endpackage

// File: rtl/pmp_trailing_ones.sv
module pmp_trailing_ones #(
    parameter int W = 32
) (
    input  logic [W-1:0]           value,
    output logic [$clog2(W+1)-1:0] count
);
    localparam int CW = $clog2(W + 1);

    always_comb begin
        logic stop;
        stop  = 1'b0;
        count = '0;
        for (int k = 0; k < W; k++) begin
            if (!stop) begin
                if (value[k]) count = count + CW'(1);
                else          stop  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pmp_napot_span.sv
module pmp_napot_span #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]   word_addr,
    output logic [XLEN+1:0]   span_lo,
    output logic [XLEN+1:0]   span_hi
);
    localparam int BW = XLEN + 2;
    localparam int CW = $clog2(XLEN + 1);

    logic [CW-1:0]   ones;
    logic [XLEN-1:0] cleared;
    logic [BW-1:0]   size_mask;

    pmp_trailing_ones #(.W(XLEN)) u_ones (
        .value (word_addr),
        .count (ones)
    );

    always_comb begin
        for (int k = 0; k < XLEN; k++) begin
            cleared[k] = word_addr[k] & (k >= int'(ones));
        end
        for (int k = 0; k < BW; k++) begin
            size_mask[k] = (k < int'(ones) + 3);
        end
        span_lo = {cleared, 2'b00};
        // base has a zero at every mask bit, so OR equals the sum
        span_hi = span_lo | size_mask;
    end
endmodule

// File: rtl/pmp_entry_decode.sv
module pmp_entry_decode
    import pmp_bounds_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  match_mode_e     mode,
    input  logic [XLEN-1:0] cur_addr,
    input  logic [XLEN-1:0] prev_addr,
    output logic [XLEN+1:0] lo,
    output logic [XLEN+1:0] hi,
    output logic            on
);
    localparam int BW = XLEN + 2;

    logic [BW-1:0] napot_lo, napot_hi;

    pmp_napot_span #(.XLEN(XLEN)) u_span (
        .word_addr (cur_addr),
        .span_lo   (napot_lo),
        .span_hi   (napot_hi)
    );

    always_comb begin
        lo = '0;
        hi = '0;
        on = 1'b1;
        unique case (mode)
            MATCH_TOR: begin
                lo = {prev_addr, 2'b00};
                hi = {cur_addr, 2'b00} - BW'(1);
            end
            MATCH_NA4: begin
                lo = {cur_addr, 2'b00};
                hi = {cur_addr, 2'b11};
            end
            MATCH_NAPOT: begin
                lo = napot_lo;
                hi = napot_hi;
            end
            default: on = 1'b0;
        endcase
    end
endmodule

// File: rtl/pmp_region_bounds.sv
module pmp_region_bounds
    import pmp_bounds_pkg::*;
#(
    parameter int N    = 4,
    parameter int XLEN = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N-1:0]           cfg_wr,
    input  logic [N-1:0]           addr_wr,
    input  logic [2*N-1:0]         mode_flat,
    input  logic [N*XLEN-1:0]      addr_flat,
    output logic [N*(XLEN+2)-1:0]  lo_flat,
    output logic [N*(XLEN+2)-1:0]  hi_flat,
    output logic [N-1:0]           active
);
    localparam int BW = XLEN + 2;

    typedef struct packed {
        logic [BW-1:0] lo;
        logic [BW-1:0] hi;
        logic          on;
    } bound_t;

    bound_t [N-1:0] st_d, st_q, calc;
    logic   [N-1:0] refresh;

    for (genvar g = 0; g < N; g++) begin : g_entry
        logic [XLEN-1:0] prev;
        if (g == 0) begin : g_first
            assign prev       = '0;
            assign refresh[g] = cfg_wr[g] | addr_wr[g];
        end else begin : g_rest
            assign prev       = addr_flat[(g-1)*XLEN +: XLEN];
            assign refresh[g] = cfg_wr[g] | addr_wr[g] | addr_wr[g-1];
        end

        pmp_entry_decode #(.XLEN(XLEN)) u_dec (
            .mode      (match_mode_e'(mode_flat[2*g +: 2])),
            .cur_addr  (addr_flat[g*XLEN +: XLEN]),
            .prev_addr (prev),
            .lo        (calc[g].lo),
            .hi        (calc[g].hi),
            .on        (calc[g].on)
        );

        assign lo_flat[g*BW +: BW] = st_q[g].lo;
        assign hi_flat[g*BW +: BW] = st_q[g].hi;
        assign active[g]           = st_q[g].on;
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (refresh[i]) st_d[i] = calc[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pmp_region_bounds_chk.sv
module pmp_region_bounds_chk #(
    parameter int N    = 4,
    parameter int XLEN = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [N-1:0]           cfg_wr,
    input logic [N-1:0]           addr_wr,
    input logic [2*N-1:0]         mode_flat,
    input logic [N*XLEN-1:0]      addr_flat,
    input logic [N*(XLEN+2)-1:0]  lo_flat,
    input logic [N*(XLEN+2)-1:0]  hi_flat,
    input logic [N-1:0]           active
);
    localparam int BW = XLEN + 2;

    // R7: no strobe anywhere -> nothing moves
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_wr | addr_wr) == '0) |=> ($stable(lo_flat) && $stable(hi_flat) && $stable(active)));

    // R3: entry 0 in top-of-range starts at zero
    a_r3_first_base: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_wr[0] | addr_wr[0]) && mode_flat[1:0] == 2'd1) |=> (lo_flat[BW-1:0] == '0));

    for (genvar g = 0; g < N; g++) begin : g_chk
        logic [BW-1:0] lo_g, hi_g, diff_g;
        assign lo_g   = lo_flat[g*BW +: BW];
        assign hi_g   = hi_flat[g*BW +: BW];
        assign diff_g = hi_g - lo_g;

        // R1: inactive entry carries zero bounds
        a_r1_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !active[g] |-> (lo_g == '0 && hi_g == '0));

        // R4: four-byte window
        a_r4_na4_width: assert property (@(posedge clk) disable iff (!rst_n)
            ((cfg_wr[g] | addr_wr[g]) && mode_flat[2*g +: 2] == 2'd2) |=> (diff_g == BW'(3)));

        // R5: power-of-two size, base aligned to it
        a_r5_napot_shape: assert property (@(posedge clk) disable iff (!rst_n)
            ((cfg_wr[g] | addr_wr[g]) && mode_flat[2*g +: 2] == 2'd3)
            |=> (((diff_g & (diff_g + BW'(1))) == '0) && ((lo_g & diff_g) == '0) && active[g]));
    end
endmodule

bind pmp_region_bounds pmp_region_bounds_chk #(.N(N), .XLEN(XLEN)) u_chk (.*);

// File: tb/pmp_region_bounds_test.sv
module pmp_region_bounds_test;
    localparam int N    = 4;
    localparam int XLEN = 32;
    localparam int BW   = XLEN + 2;
    localparam int NV   = 9;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic [N-1:0]         cfg_wr, addr_wr;
    logic [2*N-1:0]       mode_flat;
    logic [N*XLEN-1:0]    addr_flat;
    logic [N*BW-1:0]      lo_flat, hi_flat;
    logic [N-1:0]         active;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    pmp_region_bounds #(.N(N), .XLEN(XLEN)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .addr_wr(addr_wr),
        .mode_flat(mode_flat), .addr_flat(addr_flat),
        .lo_flat(lo_flat), .hi_flat(hi_flat), .active(active)
    );

    // vectors for entry 1, entry 0 register supplies the previous address
    localparam logic [1:0]      V_MODE [NV] = '{2'd3, 2'd3, 2'd3, 2'd2, 2'd1, 2'd3, 2'd3, 2'd0, 2'd2};
    localparam logic [XLEN-1:0] V_PREV [NV] = '{32'h0, 32'h0, 32'h0, 32'h0, 32'h100, 32'h0, 32'h0, 32'h0, 32'h0};
    localparam logic [XLEN-1:0] V_ADDR [NV] = '{32'h0, 32'h1000_0001, 32'h0000_0203, 32'h400, 32'h200,
                                               32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h1234, 32'hFFFF_FFFF};
    localparam logic [BW-1:0]   V_LO   [NV] = '{34'h0, 34'h4000_0000, 34'h800, 34'h1000, 34'h400,
                                               34'h0, 34'h0, 34'h0, 34'h3_FFFF_FFFC};
    localparam logic [BW-1:0]   V_HI   [NV] = '{34'h7, 34'h4000_000F, 34'h81F, 34'h1003, 34'h7FF,
                                               34'h3_FFFF_FFFF, 34'h3_FFFF_FFFF, 34'h0, 34'h3_FFFF_FFFF};
    localparam string           V_TAG  [NV] = '{"R5", "R5", "R5", "R4", "R2", "R6", "R6", "R1", "R4"};

    task automatic chk(string tag, logic [BW-1:0] act, logic [BW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_entry(int e, logic [1:0] m, logic [XLEN-1:0] a);
        mode_flat[2*e +: 2]    = m;
        addr_flat[e*XLEN +: XLEN] = a;
    endtask

    task automatic pulse(logic [N-1:0] cw, logic [N-1:0] aw);
        cfg_wr  = cw;
        addr_wr = aw;
        @(negedge clk);
        cfg_wr  = '0;
        addr_wr = '0;
    endtask

    function automatic logic [BW-1:0] lo_of(int e); return lo_flat[e*BW +: BW]; endfunction
    function automatic logic [BW-1:0] hi_of(int e); return hi_flat[e*BW +: BW]; endfunction

    initial begin
        #(20 * 100000);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_wr = '0; addr_wr = '0;
        mode_flat = '1; addr_flat = '1;
        repeat (3) @(negedge clk);
        // R9 reset state
        for (int e = 0; e < N; e++) begin
            chk("R9 lo", lo_of(e), '0);
            chk("R9 hi", hi_of(e), '0);
            chk("R9 active", BW'(active[e]), '0);
        end
        rst_n = 1'b1;
        mode_flat = '0; addr_flat = '0;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            set_entry(0, 2'd0, V_PREV[v]);
            set_entry(1, V_MODE[v], V_ADDR[v]);
            pulse(4'b0010, 4'b0010);
            chk(V_TAG[v], lo_of(1), V_LO[v]);
            chk(V_TAG[v], hi_of(1), V_HI[v]);
            chk("R1 active", BW'(active[1]), BW'(V_MODE[v] != 2'd0));
        end

        // R3: entry 0 top-of-range ignores other registers
        set_entry(3, 2'd0, 32'hDEAD_BEEF);
        set_entry(0, 2'd1, 32'h40);
        pulse(4'b0001, 4'b0000);
        chk("R3 lo", lo_of(0), '0);
        chk("R3 hi", hi_of(0), 34'hFF);

        // R8: address strobe on entry 1 rebuilds entry 2
        set_entry(1, 2'd2, 32'h100);
        set_entry(2, 2'd1, 32'h300);
        pulse(4'b0110, 4'b0000);
        chk("R2 lo", lo_of(2), 34'h400);
        chk("R2 hi", hi_of(2), 34'hBFF);
        set_entry(1, 2'd2, 32'h200);
        pulse(4'b0000, 4'b0010);
        chk("R8 neighbour lo", lo_of(2), 34'h800);
        chk("R8 own lo", lo_of(1), 34'h800);
        chk("R8 own hi", hi_of(1), 34'h803);

        // R8: mode strobe on entry 1 leaves entry 2 alone
        set_entry(1, 2'd2, 32'h240);
        pulse(4'b0010, 4'b0000);
        chk("R8 cfg own lo", lo_of(1), 34'h900);
        chk("R8 cfg neighbour lo", lo_of(2), 34'h800);
        chk("R8 cfg neighbour hi", hi_of(2), 34'hBFF);

        // R7: inputs change with no strobe, entry 3 holds
        set_entry(3, 2'd3, 32'h5);
        repeat (2) @(negedge clk);
        chk("R7 hold lo", lo_of(3), '0);
        chk("R7 hold hi", hi_of(3), '0);
        chk("R7 hold active", BW'(active[3]), '0);
        pulse(4'b1000, 4'b0000);
        chk("R7 update lo", lo_of(3), 34'h10);
        chk("R7 update hi", hi_of(3), 34'h1F);
        chk("R7 update active", BW'(active[3]), BW'(1));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule